// File: doc/BRIEF.md
# ISA-Style Slave to Valid/Acknowledge Core Bridge

This block connects a peripheral core with a simple synchronous request channel to a shared peripheral bus. The bus has strobes and a ready line. A bus master first presents an address while pulsing the address-latch strobe. The bridge keeps that address and checks whether it falls inside its own window, which is a power-of-two region starting at an aligned base. When the master then raises a read or write strobe on a selected address, the bridge issues exactly one request to the core. The request carries a valid bit, a read flag, the offset within the window and, for writes, the data sampled from the shared data bus.

While the core works, the bridge pulls ready low, so the bus cycle stretches to whatever length the core needs. When the acknowledge arrives, the bridge registers the read data and lets ready go high. For reads it drives that data onto the shared bus for as long as the read strobe stays high. Accesses outside the window leave both ready and the data bus undriven. Strobes are active high. Reset is synchronous and active high.

Top module: `isa_core_bridge`

## Requirements
- R1: On a clock edge where `bus_ale` is 1, the bridge stores `bus_addr` and marks itself selected if and only if BASE_ADDR <= `bus_addr` < BASE_ADDR + 2^WIN_W (default base 0x040000, window 256). Only a selected address may start a core request.
- R2: The clock edge that first sees a selected read or write strobe in the idle state sets `core_valid` to 1 after that edge. At the same time it sets `core_read` (1 for read, 0 for write), `core_addr` (the low WIN_W bits of the latched address) and `core_wdata` (sampled from `bus_data`).
- R3: While `core_valid` is 1 and `core_ack` is 0, `core_valid`, `core_read`, `core_addr` and `core_wdata` hold their values.
- R4: `core_valid` is 0 in the cycle after the edge that samples `core_ack` = 1. A strobe held high for any length produces exactly one request.
- R5: During a selected access, `bus_rdy` is driven 0 from the moment the strobe is raised. It is driven 1 from the clock edge that samples `core_ack` onward, until the strobe falls. With the acknowledge on the k-th cycle of valid (k = 0 being the first), ready reads 1 at the second plus k-th falling clock edge after the strobe is raised.
- R6: During a selected read strobe, `bus_data` is driven with the `core_rdata` value registered at the acknowledge edge. At all other times the bridge leaves `bus_data` undriven.
- R7: When an access targets an unselected address, `bus_rdy` and `bus_data` are left undriven and no request is made.
- R8: After reset, `core_valid` is 0, the bridge is unselected, and both `bus_rdy` and `bus_data` are undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (23) | Bus address |
| bus_ale | input | 1 | Address-latch strobe |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_data | inout | DATA_W (32) | Shared bidirectional data bus |
| bus_rdy | output | 1 | Ready; 0 stretches the cycle, undriven when not selected |
| core_valid | output | 1 | Request pending toward the core |
| core_read | output | 1 | 1 = read request, 0 = write request |
| core_addr | output | WIN_W (8) | Offset within the window |
| core_wdata | output | DATA_W (32) | Write data toward the core |
| core_ack | input | 1 | Core acknowledge |
| core_rdata | input | DATA_W (32) | Read data, valid with acknowledge |

## Verification
The bench drives addresses one below the base, at the base and at the last offset, and one past the top of the window. A decoder off by one would either issue a request or pull ready at the wrong place, and the bench reports it at the ports. The bench holds a read strobe for many cycles after ready rises, which catches a sequencer that re-arms while the strobe is still high and issues a second request. It also varies the acknowledge delay to pin the exact falling edge on which ready rises, so an extra register stage, or a ready that rises before the data is registered, shows up as a wrong wait count or wrong read data. Between accesses the bench watches every cycle for a data bus that is still driven.

// File: rtl/isabr_pkg.sv
package isabr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    // aligned power-of-two window match
    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input int unsigned wbits);
        return (a >> wbits) == (base >> wbits);
    endfunction

endpackage

// File: rtl/isabr_decode.sv
module isabr_decode #(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned WIN_W  = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_q,
    output logic [WIN_W-1:0]  ofs_q
);
    import isabr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            ofs_q <= '0;
        end else if (ale) begin
            sel_q <= in_window(32'(addr), 32'(BASE_ADDR), WIN_W);
            ofs_q <= addr[WIN_W-1:0];
        end
    end
endmodule

// File: rtl/isabr_seq.sv
module isabr_seq #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    output logic              valid,
    output logic              read,
    output logic [OFS_W-1:0]  req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic              done
);
    import isabr_pkg::*;

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            valid     <= 1'b0;
            read      <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (sel && (rd || wr)) begin
                    state     <= SEQ_REQ;
                    valid     <= 1'b1;
                    read      <= rd;
                    req_addr  <= ofs;
                    req_wdata <= bus_wdata;
                end
                SEQ_REQ: if (ack) begin
                    state   <= SEQ_DONE;
                    valid   <= 1'b0;
                    rdata_q <= rdata;
                end
                SEQ_DONE: if (!rd && !wr) state <= SEQ_IDLE;
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign done = (state == SEQ_DONE);
endmodule

// File: rtl/isabr_drive.sv
module isabr_drive (
    input  logic sel,
    input  logic rd,
    input  logic wr,
    input  logic done,
    output logic data_oe,
    output logic rdy_oe,
    output logic rdy_val
);
    always_comb begin
        data_oe = sel && rd;
        rdy_oe  = sel && (rd || wr);
        rdy_val = done;
    end
endmodule

// File: rtl/isa_core_bridge.sv
module isa_core_bridge #(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WIN_W  = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 23'h04_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ale,
    input  logic              bus_rd,
    input  logic              bus_wr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              bus_rdy,
    output logic              core_valid,
    output logic              core_read,
    output logic [WIN_W-1:0]  core_addr,
    output logic [DATA_W-1:0] core_wdata,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] core_rdata
);
    logic              sel_q;
    logic [WIN_W-1:0]  ofs_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done;
    logic              data_oe;
    logic              rdy_oe;
    logic              rdy_val;

    isabr_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .clk(clk), .rst(rst), .ale(bus_ale), .addr(bus_addr),
        .sel_q(sel_q), .ofs_q(ofs_q)
    );

    isabr_seq #(.DATA_W(DATA_W), .OFS_W(WIN_W)) u_seq (
        .clk(clk), .rst(rst), .sel(sel_q), .rd(bus_rd), .wr(bus_wr),
        .ofs(ofs_q), .bus_wdata(bus_data), .ack(core_ack), .rdata(core_rdata),
        .valid(core_valid), .read(core_read), .req_addr(core_addr),
        .req_wdata(core_wdata), .rdata_q(rdata_q), .done(done)
    );

    isabr_drive u_drv (
        .sel(sel_q), .rd(bus_rd), .wr(bus_wr), .done(done),
        .data_oe(data_oe), .rdy_oe(rdy_oe), .rdy_val(rdy_val)
    );

    assign bus_data = data_oe ? rdata_q : {DATA_W{1'bz}};
    assign bus_rdy  = rdy_oe  ? rdy_val : 1'bz;
endmodule

// File: rtl/isabr_chk.sv
module isabr_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OFS_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              sel,
    input logic              data_oe,
    input logic              rdy_oe,
    input logic              rdy_val,
    input logic              core_valid,
    input logic              core_read,
    input logic [OFS_W-1:0]  core_addr,
    input logic [DATA_W-1:0] core_wdata,
    input logic              core_ack
);
    // R1
    req_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_valid) |-> $past(sel));

    // R3
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        core_valid && !core_ack |=> core_valid);

    // R3
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        core_valid && !core_ack |=> $stable(core_read) && $stable(core_addr) && $stable(core_wdata));

    // R4
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        core_valid && core_ack |=> !core_valid);

    // R5
    rdy_wait_chk: assert property (@(posedge clk) disable iff (rst)
        core_valid && (bus_rd || bus_wr) |-> rdy_oe && !rdy_val);

    // R6
    data_oe_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> bus_rd && sel);
endmodule

bind isa_core_bridge isabr_chk #(.DATA_W(DATA_W), .OFS_W(WIN_W)) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .sel(sel_q),
    .data_oe(data_oe), .rdy_oe(rdy_oe), .rdy_val(rdy_val),
    .core_valid(core_valid), .core_read(core_read), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_ack(core_ack)
);

// File: tb/isa_core_bridge_test.sv
module isa_core_bridge_test;
    localparam logic [22:0] BASE = 23'h04_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [22:0] bus_addr = '0;
    logic        bus_ale = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    wire  [31:0] bus_data;
    wire         bus_rdy;
    logic        core_valid, core_read;
    logic [7:0]  core_addr;
    logic [31:0] core_wdata;
    logic        core_ack = 1'b0;
    logic [31:0] core_rdata = '0;

    logic        tb_drv = 1'b0;
    logic [31:0] tb_wd = '0;
    assign bus_data = tb_drv ? tb_wd : 32'bz;

    pullup (bus_rdy);
    for (genvar i = 0; i < 32; i++) begin : g_pu
        pullup (bus_data[i]);
    end

    isa_core_bridge uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_ale(bus_ale),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_data(bus_data), .bus_rdy(bus_rdy),
        .core_valid(core_valid), .core_read(core_read), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_ack(core_ack), .core_rdata(core_rdata)
    );

    always #5 clk = ~clk;

    int errors = 0, checks = 0, cycles = 0;
    int ack_delay = 0, req_count = 0, cnt = 0;
    bit prev_valid = 0, exp_rd_sel = 0;
    logic [7:0]  last_addr = '0;
    logic        last_read = 1'b0;
    logic [31:0] last_wdata = '0;

    function automatic logic [31:0] pat(input logic [7:0] o);
        return 32'hC0DE_0000 | {24'h0, o} | ({24'h0, o} << 8);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural core: acknowledges on the ack_delay-th cycle of valid
    always @(negedge clk) begin
        if (rst) begin
            core_ack = 1'b0;
            prev_valid = 0;
        end else begin
            if (core_valid) begin
                if (!prev_valid) begin cnt = 0; req_count++; end
                else cnt++;
                if (cnt == ack_delay) begin
                    core_ack   = 1'b1;
                    core_rdata = pat(core_addr);
                    last_addr  = core_addr;
                    last_read  = core_read;
                    last_wdata = core_wdata;
                end else core_ack = 1'b0;
            end else core_ack = 1'b0;
            prev_valid = core_valid;
            // R6 / R7: bus released whenever no selected read and bench not driving
            if (!tb_drv && !exp_rd_sel)
                chk(bus_data == 32'hFFFF_FFFF, "R6 bus released", bus_data, 32'hFFFF_FFFF);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic access(input bit rd, input logic [22:0] a, input logic [31:0] wd,
                          input int d, input bit sel_exp, input int hold);
        int r0 = req_count;
        int w = 0;
        ack_delay = d;
        @(negedge clk); bus_addr = a; bus_ale = 1'b1;
        @(negedge clk); bus_ale = 1'b0;
        if (rd) bus_rd = 1'b1;
        else begin bus_wr = 1'b1; tb_drv = 1'b1; tb_wd = wd; end
        exp_rd_sel = rd && sel_exp;
        if (sel_exp) begin
            do begin
                @(negedge clk); w++;
                if (bus_rdy !== 1'b1 && w == 1)
                    chk(bus_rdy == 1'b0, "R5 ready low at start", 32'(bus_rdy), 0);
            end while (bus_rdy !== 1'b1 && w < 60);
            chk(w == d + 2, "R5 wait length", w, d + 2);
            chk(last_addr == a[7:0], "R2 offset", 32'(last_addr), 32'(a[7:0]));
            chk(last_read == rd, "R2 read flag", 32'(last_read), 32'(rd));
            if (rd) chk(bus_data == pat(a[7:0]), "R6 read data", bus_data, pat(a[7:0]));
            else    chk(last_wdata == wd, "R2 write data", last_wdata, wd);
            repeat (hold) begin
                @(negedge clk);
                chk(core_valid == 1'b0, "R4 no re-request", 32'(core_valid), 0);
                chk(bus_rdy == 1'b1, "R5 ready stays high", 32'(bus_rdy), 1);
            end
            chk(req_count == r0 + 1, "R4 one request per strobe", req_count, r0 + 1);
        end else begin
            repeat (6) begin
                @(negedge clk);
                chk(bus_rdy == 1'b1, "R7 ready undriven", 32'(bus_rdy), 1);
                if (rd) chk(bus_data == 32'hFFFF_FFFF, "R7 data undriven", bus_data, 32'hFFFF_FFFF);
            end
            chk(req_count == r0, "R1 no request outside window", req_count, r0);
        end
        @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0; tb_drv = 1'b0; exp_rd_sel = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(core_valid == 1'b0, "R8 valid", 32'(core_valid), 0);
        chk(bus_rdy == 1'b1, "R8 ready undriven", 32'(bus_rdy), 1);
        chk(bus_data == 32'hFFFF_FFFF, "R8 data undriven", bus_data, 32'hFFFF_FFFF);
        @(negedge clk); rst = 1'b0;
        // R8: strobe before any address latch must not start a request
        @(negedge clk); bus_rd = 1'b1;
        repeat (4) @(negedge clk);
        chk(req_count == 0, "R8 unselected after reset", req_count, 0);
        bus_rd = 1'b0;
        @(negedge clk);

        access(1'b0, BASE + 23'h10, 32'hDEAD_BEEF, 0, 1'b1, 0);   // R2 write, fast ack
        access(1'b1, BASE + 23'h24, '0, 3, 1'b1, 0);               // R6 read, slow ack
        access(1'b0, BASE + 23'hFF, 32'h1357_9BDF, 5, 1'b1, 2);    // R1 top of window
        access(1'b1, BASE, '0, 1, 1'b1, 0);                         // R1 base
        access(1'b1, BASE - 23'h1, '0, 0, 1'b0, 0);                 // R7 just below
        access(1'b0, BASE + 23'h100, 32'h0F0F_0F0F, 0, 1'b0, 0);    // R7 just above
        access(1'b1, BASE + 23'h5A, '0, 2, 1'b1, 12);               // R4 long strobe
        access(1'b0, BASE + 23'h01, 32'h8000_0001, 7, 1'b1, 0);     // R3 long wait

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule